// File: doc/BRIEF.md
# Dual-Address Two-Wire Slave Address Recognizer

The block watches the clock and data lines of a two-wire serial bus from a fast system clock. It finds start and stop conditions and shifts in the first byte sent after each start. The upper seven bits of that byte are compared against two slave addresses, each held in its own programmable register. On a hit the block pulses a match strobe, reports which address hit and the read/write bit, and pulls the data line low for the acknowledge clock. On a miss it stays off the bus until the next start.

Bit 0 of each address register is a format bit. The two format bits together select one of four modes: both addresses live, only the first, only the second, or a non-addressed synchronous format in which nothing is recognized. The first register is always reachable through a small register port. The second register shares its slot with a data holding register, so it can only be reached while the interface enable is low. Data bytes after the address, clock stretching and master operation are handled elsewhere.

Top module: `tw_slave_addr_det`

## Requirements
- R1: After reset the first address register reads 0x00 and the second reads 0x01, which selects first-address-only mode. `sda_oe_o` and `match_o` are 0.
- R2: A start is SDA falling while SCL is high. After it, the next eight SCL rising edges capture one byte MSB first. The upper seven bits are the address and bit 0 is read/write (1 = read).
- R3: The mode is {first register bit 0, second register bit 0}. 00 recognizes both addresses, 01 recognizes only the first, and 10 recognizes only the second. An address that is not enabled is never acknowledged.
- R4: In mode 11 no byte is matched and `sda_oe_o` is never asserted.
- R5: On a match, `match_o` is high for exactly one clock. `match_id_o` then holds 0 if the first address matched and 1 if the second matched. `rw_o` holds the captured bit 0. Both hold until the next match.
- R6: When both addresses are enabled and equal, the first address wins (`match_id_o` = 0).
- R7: After a match, `sda_oe_o` (1 = pull SDA low) rises only after SCL falls at the end of the eighth bit. It stays high through the ninth SCL high phase and drops after the ninth SCL fall.
- R8: After a miss the block does not drive SDA. Later bytes, even ones matching an address, are ignored until a new start.
- R9: A repeated start restarts address capture from bit 7, whether it comes part-way through a byte or after a completed match.
- R10: A stop (SDA rising while SCL is high) releases SDA and returns to idle. Bits clocked after a stop with no new start never produce a match.
- R11: Register port: `reg_sel_i` = 0 reaches the first address register at all times. With `reg_sel_i` = 1, writes and reads reach the second address register when `if_en_i` = 0, and a data holding register when `if_en_i` = 1. Writes in that case leave the second address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| if_en_i | input | 1 | Interface enable; redirects the shared register slot |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = first address, 1 = shared slot |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| match_o | output | 1 | One-clock address match strobe |
| match_id_o | output | 1 | 0 = first address matched, 1 = second |
| rw_o | output | 1 | Captured read/write bit of the matched byte |

## Verification
The bench drives the same pair of addresses through all four modes. A decoder with the format bits swapped or mis-mapped would acknowledge a disabled address, or stay silent on an enabled one, in at least one of them. Equal addresses in mode 00 catch a priority that favours the second register. A miss followed by a matching byte with no new start catches a recognizer that re-arms after every byte. A partial byte cut by a repeated start catches a bit counter that does not clear. A stop followed by eight clean bits catches stop handling that leaves capture armed. Register traffic with the enable high catches a second address register that is still writable, which would show up as a changed read-back once the enable drops.

// File: rtl/tw_addr_pkg.sv
package tw_addr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACK  = 2'd2,
    ST_HOLD = 2'd3
  } det_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_chain, sda_chain;
  logic          scl_d, sda_d;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            scl_chain[0] <= 1'b1;
            sda_chain[0] <= 1'b1;
          end else begin
            scl_chain[0] <= scl_i;
            sda_chain[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_chain[g-1];
            sda_chain[g] <= sda_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_chain[LAST];
      sda_d <= sda_chain[LAST];
    end
  end

  assign scl_o      = scl_chain[LAST];
  assign sda_o      = sda_chain[LAST];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges only count as framing while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/tw_addr_regs.sv
module tw_addr_regs #(
  parameter int  REG_W   = 8,
  parameter logic [REG_W-1:0] RST_A = '0,
  parameter logic [REG_W-1:0] RST_B = REG_W'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             if_en_i,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] addr_a_o,
  output logic [REG_W-1:0] addr_b_o
);
  logic [REG_W-1:0] a_q, b_q, dat_q;
  logic             b_open;

  assign b_open = ~if_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= RST_A;
      b_q   <= RST_B;
      dat_q <= '0;
    end else if (wr_i) begin
      if (!sel_i)      a_q   <= wdata_i;
      else if (b_open) b_q   <= wdata_i;
      else             dat_q <= wdata_i;
    end
  end

  always_comb begin
    if (!sel_i)      rdata_o = a_q;
    else if (b_open) rdata_o = b_q;
    else             rdata_o = dat_q;
  end

  assign addr_a_o = a_q;
  assign addr_b_o = b_q;
endmodule

// File: rtl/tw_addr_cmp.sv
module tw_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0] byte_i,
  input  logic [ADDR_W:0] addr_a_i,
  input  logic [ADDR_W:0] addr_b_i,
  output logic            hit_o,
  output logic            id_o
);
  localparam int SLOTS = 2;

  logic [SLOTS-1:0][ADDR_W:0] regs;
  logic [SLOTS-1:0]           slot_en, slot_hit;

  assign regs[0] = addr_a_i;
  assign regs[1] = addr_b_i;

  // mode {a[0], b[0]}: first live when a[0]=0, second live when b[0]=0
  assign slot_en[0] = ~addr_a_i[0];
  assign slot_en[1] = ~addr_b_i[0];

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot_hit[s] = slot_en[s] & (byte_i[ADDR_W:1] == regs[s][ADDR_W:1]);
    end
  endgenerate

  assign hit_o = |slot_hit;
  assign id_o  = ~slot_hit[0];
endmodule

// File: rtl/tw_slave_addr_det.sv
module tw_slave_addr_det
  import tw_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              if_en_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W:0]   reg_wdata_i,
  output logic [ADDR_W:0]   reg_rdata_o,
  output logic              match_o,
  output logic              match_id_o,
  output logic              rw_o
);
  localparam int REG_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(REG_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W);

  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W:0]  addr_a, addr_b, nxt_byte;
  logic             hit, hit_id;

  det_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] sh_q;
  logic             oe_q, match_q, id_q, rw_q;

  tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_addr_regs #(.REG_W(REG_W), .RST_A('0), .RST_B(REG_W'(1))) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .if_en_i  (if_en_i),
    .wr_i     (reg_wr_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .addr_a_o (addr_a),
    .addr_b_o (addr_b)
  );

  assign nxt_byte = {sh_q, sda_s};

  tw_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_i   (nxt_byte),
    .addr_a_i (addr_a),
    .addr_b_i (addr_b),
    .hit_o    (hit),
    .id_o     (hit_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      match_q <= 1'b0;
      id_q    <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise) begin
            sh_q  <= nxt_byte[ADDR_W-1:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (hit) begin
                match_q <= 1'b1;
                id_q    <= hit_id;
                rw_q    <= nxt_byte[0];
                state_q <= ST_ACK;
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end
          // first fall ends bit 8: drive; second fall ends bit 9: release
          ST_ACK: if (scl_fall) begin
            if (!oe_q) oe_q <= 1'b1;
            else begin
              oe_q    <= 1'b0;
              state_q <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign match_o    = match_q;
  assign match_id_o = id_q;
  assign rw_o       = rw_q;
endmodule

// File: rtl/tw_slave_addr_det_chk.sv
module tw_slave_addr_det_chk
  import tw_addr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       match_o,
  input logic       sda_oe_o,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       fs,
  input logic       fsx,
  input det_state_e state_q
);
  // R5
  match_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  // R4
  sync_fmt_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> !($past(fs) && $past(fsx)));

  // R7
  ack_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  // R7
  ack_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> (!$past(scl_s) || $past(stop_det) || $past(start_det)));

  // R8
  drive_only_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_q == ST_ACK));

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!sda_oe_o && state_q == ST_IDLE));
endmodule

bind tw_slave_addr_det tw_slave_addr_det_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .match_o   (match_o),
  .sda_oe_o  (sda_oe_o),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .fs        (addr_a[0]),
  .fsx       (addr_b[0]),
  .state_q   (state_q)
);

// File: tb/tb_tw_slave_addr_det.sv
module tb_tw_slave_addr_det;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl = 1'b1, m_sda = 1'b1;
  logic       sda_line;
  logic       sda_oe_o, if_en_i = 1'b0, reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic       match_o, match_id_o, rw_o;

  int n_chk = 0, n_fail = 0;
  int mcnt = 0, dbl = 0;
  logic mq_d = 1'b0, last_id = 1'b0, last_rw = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe_o;

  tw_slave_addr_det dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .if_en_i(if_en_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .match_o(match_o), .match_id_o(match_id_o), .rw_o(rw_o)
  );

  always @(posedge clk) begin
    mq_d <= match_o;
    if (match_o) begin
      mcnt    <= mcnt + 1;
      last_id <= match_id_o;
      last_rw <= rw_o;
      if (mq_d) dbl <= dbl + 1;
    end
  end

  task automatic chk(input string msg, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin m_sda = 1'b1; wq(); scl = 1'b1; wq(); end
    else begin m_sda = 1'b1; wq(); end
    m_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b);
    m_sda = b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    ack = ~sda_line;
    wq();
    scl = 1'b0; wq(); wq();
  endtask

  task automatic reg_write(input logic sel, input logic en, input logic [7:0] d);
    @(negedge clk);
    reg_sel_i = sel; if_en_i = en; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic sel, input logic en, output logic [7:0] d);
    @(negedge clk);
    reg_sel_i = sel; if_en_i = en;
    #1 d = reg_rdata_o;
  endtask

  task automatic xfer(input logic [7:0] b, input logic exp_ack, input logic exp_id,
                      input string tag);
    int m0;
    logic ack;
    m0 = mcnt;
    bus_start();
    send_byte(b, ack);
    chk({tag, " ack"}, ack, exp_ack);
    chk({tag, " match count"}, mcnt - m0, exp_ack ? 1 : 0);
    if (exp_ack) begin
      chk({tag, " R5 id"}, last_id, exp_id);
      chk({tag, " R5 rw"}, last_rw, b[0]);
    end
    chk({tag, " R7 released after ack"}, sda_oe_o, 0);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_read(1'b0, 1'b0, d); chk("R1 first reg reset", d, 8'h00);
    reg_read(1'b1, 1'b0, d); chk("R1 second reg reset", d, 8'h01);
    chk("R1 sda_oe reset", sda_oe_o, 0);
    chk("R1 match reset", match_o, 0);
  endtask

  task automatic t_mode01();
    reg_write(1'b0, 1'b0, 8'h54);
    xfer(8'h55, 1'b1, 1'b0, "R2 R3 mode01 first read");
    xfer(8'h54, 1'b1, 1'b0, "R2 mode01 first write");
    reg_write(1'b1, 1'b0, 8'h67);
    xfer(8'h66, 1'b0, 1'b0, "R3 mode01 second ignored");
  endtask

  task automatic t_mode00();
    reg_write(1'b0, 1'b0, 8'h54);
    reg_write(1'b1, 1'b0, 8'h66);
    xfer(8'h66, 1'b1, 1'b1, "R3 mode00 second");
    xfer(8'h55, 1'b1, 1'b0, "R3 mode00 first");
    xfer(8'h12, 1'b0, 1'b0, "R3 mode00 other");
  endtask

  task automatic t_mode10();
    reg_write(1'b0, 1'b0, 8'h55);
    reg_write(1'b1, 1'b0, 8'h66);
    xfer(8'h54, 1'b0, 1'b0, "R3 mode10 first ignored");
    xfer(8'h67, 1'b1, 1'b1, "R3 mode10 second");
  endtask

  task automatic t_mode11();
    reg_write(1'b0, 1'b0, 8'h55);
    reg_write(1'b1, 1'b0, 8'h67);
    xfer(8'h54, 1'b0, 1'b0, "R4 mode11 first");
    xfer(8'h66, 1'b0, 1'b0, "R4 mode11 second");
  endtask

  task automatic t_prio();
    reg_write(1'b0, 1'b0, 8'h54);
    reg_write(1'b1, 1'b0, 8'h54);
    xfer(8'h55, 1'b1, 1'b0, "R6 equal addresses");
  endtask

  task automatic t_ignore();
    int m0;
    logic ack;
    reg_write(1'b0, 1'b0, 8'h54);
    reg_write(1'b1, 1'b0, 8'h01);
    m0 = mcnt;
    bus_start();
    send_byte(8'h12, ack);
    chk("R8 miss nack", ack, 0);
    send_byte(8'h54, ack);
    chk("R8 later byte ignored ack", ack, 0);
    chk("R8 later byte no match", mcnt - m0, 0);
    bus_stop();
  endtask

  task automatic t_rstart();
    int m0;
    logic ack;
    m0 = mcnt;
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start();
    send_byte(8'h55, ack);
    chk("R9 rstart mid byte ack", ack, 1);
    chk("R9 rstart mid byte match", mcnt - m0, 1);
    bus_start();
    send_byte(8'h54, ack);
    chk("R9 rstart after match ack", ack, 1);
    chk("R9 rstart after match count", mcnt - m0, 2);
    chk("R9 rw after rstart", last_rw, 0);
    bus_stop();
  endtask

  task automatic t_stop();
    int m0;
    logic [7:0] b;
    m0 = mcnt;
    b = 8'h54;
    bus_start();
    bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_stop();
    scl = 1'b0; wq();
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    chk("R10 no drive after stop", sda_oe_o, 0);
    wq();
    chk("R10 no match after stop", mcnt - m0, 0);
    m_sda = 1'b0; wq();
    bus_stop();
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_write(1'b1, 1'b0, 8'h3A);
    reg_write(1'b1, 1'b1, 8'hC5);
    reg_read(1'b1, 1'b1, d); chk("R11 data slot with enable", d, 8'hC5);
    reg_read(1'b1, 1'b0, d); chk("R11 second reg protected", d, 8'h3A);
    reg_write(1'b0, 1'b1, 8'h9E);
    reg_read(1'b0, 1'b1, d); chk("R11 first reg with enable", d, 8'h9E);
    if_en_i = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mode01();
    t_mode00();
    t_mode10();
    t_mode11();
    t_prio();
    t_ignore();
    t_rstart();
    t_stop();
    t_regs();
    repeat (10) @(negedge clk);
    chk("R5 strobe one cycle", dbl, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule